// File: doc/BRIEF.md
# CRC-4 multiframe checker

The checker sits on a received 2.048 Mbit/s framed bit stream, one bit per clock. Frame alignment is found elsewhere. Two strobes carry it to this block: `ts0_gate` is high for the eight bits of timeslot 0 of every frame, and `fas_frame` is high during timeslot 0 of the frames that carry the frame alignment word. The first bit of timeslot 0 in the other frames carries the multiframe alignment word. The checker hunts for that word, and once it is found, it counts frames 0 to 15 of the 16-frame multiframe.

While aligned, the block computes a CRC-4 over each half of the multiframe (a sub-multiframe of eight frames). In that sum the check-bit positions are taken as zero. It compares the result with the four check bits that arrive in the first bit of the sync frames of the following sub-multiframe. One error flag reports each sub-multiframe. Each flag may change only at a fixed point of the multiframe. Two position strobes mark frames 13 and 15, so that a downstream receiver can pick up the spare bits of those frames.

Top module: `crc4_mf_checker`

## Requirements
- R1: During and right after reset (`rst` high, synchronous), `mf_alarm` is 1 and `smf1_err`, `smf2_err`, `f13_mark` and `f15_mark` are 0.
- R2: A frame starts on the first clock at which `ts0_gate` is high after being low. While no alignment word has been seen, `mf_alarm` stays 1 at every frame start.
- R3: At a frame start with `fas_frame` low, the first bit joins the history of non-sync first bits. When the six most recent such bits, oldest first, are 0,0,1,0,1,1, that frame is frame 11. `mf_alarm` then goes to 0 from the clock after that bit and stays 0 until reset.
- R4: If any one of the six alignment bits of a multiframe is inverted, `mf_alarm` stays 1 through frame 11 of that multiframe.
- R5: The CRC has the generator x^4+x+1 and starts at zero. It runs over every bit of a sub-multiframe, with the first bit of timeslot 0 of sync frames replaced by 0, as the remainder of M(x)·x^4. The received check bits are the first bits of the sync frames 0,2,4,6 (or 8,10,12,14) of the next sub-multiframe, in that order, holding the x^3, x^2, x^1 and x^0 coefficients. When all four match, the flag for that sub-multiframe is 0.
- R6: `smf1_err` is updated only on the clock that samples the first bit of frame 0. It becomes 1 when the CRC of frames 0–7 of the previous multiframe differs from the check bits received in frames 8–14.
- R7: `smf2_err` is updated only on the clock that samples the first bit of frame 8. It becomes 1 when the CRC of frames 8–15 differs from the check bits received in frames 0–6 that follow.
- R8: An error flag reports 0 for a sub-multiframe whose first frame started before alignment was gained.
- R9: `f13_mark` is 1 during bit 8 of timeslot 0 of frame 13 and 0 during bit 8 of every other frame. `f15_mark` behaves the same way for frame 15. Both are 0 while `mf_alarm` is 1.
- R10: While `mf_alarm` is 1, both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one data bit per rising edge |
| rst | input | 1 | Synchronous active-high reset; restarts the alignment hunt |
| rx_bit | input | 1 | Received serial data bit |
| ts0_gate | input | 1 | High during the eight bits of timeslot 0 of every frame |
| fas_frame | input | 1 | High during timeslot 0 of frames carrying the frame alignment word |
| mf_alarm | output | 1 | High while multiframe alignment is not held |
| smf1_err | output | 1 | CRC mismatch seen for the first sub-multiframe |
| smf2_err | output | 1 | CRC mismatch seen for the second sub-multiframe |
| f13_mark | output | 1 | Position strobe for frame 13 |
| f15_mark | output | 1 | Position strobe for frame 15 |

## Verification
The assertions take for granted that `ts0_gate` rises exactly once per frame, at its first bit, and that `fas_frame` is high on alternate frames in step with the multiframe count, so that every frame start is a true one. The stimulus builds each 256-bit frame as an eight-bit timeslot 0 window followed by payload, with the sync strobe on even frames only. Payload and spare bits come from a seeded random source. The alignment bits are placed in order, except for a single inverted bit in chosen multiframes. Reset is asserted only in the payload part of a frame, well clear of timeslot 0, so no partial window is ever seen as a frame start.

// File: rtl/crc4mf_pkg.sv
package crc4mf_pkg;

    localparam int                CRC_W     = 4;
    localparam logic [CRC_W-1:0]  CRC_POLY  = 4'b0011;
    localparam int                MF_FRAMES = 16;
    localparam int                FN_W      = $clog2(MF_FRAMES);
    localparam int                MAS_W     = 6;
    localparam logic [MAS_W-1:0]  MAS_WORD  = 6'b001011;
    localparam int                MAS_END   = 11;
    localparam int                N_MARKS   = 2;
    localparam int                MARK_FRAME [N_MARKS] = '{13, 15};

    typedef logic [FN_W-1:0]  frame_num_t;
    typedef logic [CRC_W-1:0] crc_t;

    localparam frame_num_t SMF2_FIRST = FN_W'(MF_FRAMES / 2);
    localparam frame_num_t MAS_FRAME  = FN_W'(MAS_END);

    typedef struct packed {
        logic start;
        logic sync_frm;
        logic bit_val;
    } ts0_evt_t;

    function automatic crc_t crc_step(crc_t cur, logic din);
        logic fb;
        fb = cur[CRC_W-1] ^ din;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/crc4mf_ts0_detect.sv
module crc4mf_ts0_detect
    import crc4mf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_bit,
    input  logic     ts0_gate,
    input  logic     fas_frame,
    output ts0_evt_t evt
);

    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b1;
        end else begin
            gate_q <= ts0_gate;
        end
    end

    always_comb begin
        evt.start    = ts0_gate && !gate_q;
        evt.sync_frm = fas_frame;
        evt.bit_val  = rx_bit;
    end

endmodule

// File: rtl/crc4mf_align.sv
module crc4mf_align
    import crc4mf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ts0_evt_t   evt,
    output logic       aligned,
    output frame_num_t cur_frame,
    output frame_num_t frame_now
);

    logic [MAS_W-1:0] hist;
    logic [MAS_W-1:0] hist_nx;
    logic             nsync_start;
    logic             hit;

    assign nsync_start = evt.start && !evt.sync_frm;
    assign hist_nx     = {hist[MAS_W-2:0], evt.bit_val};
    assign hit         = nsync_start && !aligned && (hist_nx == MAS_WORD);
    assign frame_now   = cur_frame + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist      <= '1;
            aligned   <= 1'b0;
            cur_frame <= '0;
        end else begin
            if (nsync_start) begin
                hist <= hist_nx;
            end
            if (hit) begin
                aligned   <= 1'b1;
                cur_frame <= MAS_FRAME;
            end else if (evt.start && aligned) begin
                cur_frame <= frame_now;
            end
        end
    end

endmodule

// File: rtl/crc4mf_crc_cmp.sv
module crc4mf_crc_cmp
    import crc4mf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ts0_evt_t   evt,
    input  logic       aligned,
    input  frame_num_t frame_now,
    output logic       smf1_err,
    output logic       smf2_err
);

    crc_t acc;
    crc_t held;
    crc_t rxw;
    logic held_ok;
    logic run_ok;
    logic smf_edge;
    logic cbit;
    logic mismatch;

    assign smf_edge = evt.start && aligned &&
                      ((frame_now == '0) || (frame_now == SMF2_FIRST));
    assign cbit     = evt.start && evt.sync_frm;
    assign mismatch = held_ok && (held != rxw);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            held     <= '0;
            rxw      <= '0;
            held_ok  <= 1'b0;
            run_ok   <= 1'b0;
            smf1_err <= 1'b0;
            smf2_err <= 1'b0;
        end else if (smf_edge) begin
            held    <= acc;
            held_ok <= run_ok;
            run_ok  <= 1'b1;
            acc     <= '0;
            rxw     <= {{(CRC_W-1){1'b0}}, evt.bit_val};
            if (frame_now == '0) begin
                smf1_err <= mismatch;
            end else begin
                smf2_err <= mismatch;
            end
        end else begin
            acc <= crc_step(acc, cbit ? 1'b0 : evt.bit_val);
            if (cbit) begin
                rxw <= {rxw[CRC_W-2:0], evt.bit_val};
            end
        end
    end

endmodule

// File: rtl/crc4_mf_checker.sv
module crc4_mf_checker
    import crc4mf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_bit,
    input  logic ts0_gate,
    input  logic fas_frame,
    output logic mf_alarm,
    output logic smf1_err,
    output logic smf2_err,
    output logic f13_mark,
    output logic f15_mark
);

    ts0_evt_t     evt;
    logic         aligned;
    logic         fstart;
    frame_num_t   cur_frame;
    frame_num_t   frame_now;
    logic [N_MARKS-1:0] marks;

    crc4mf_ts0_detect u_detect (
        .clk       (clk),
        .rst       (rst),
        .rx_bit    (rx_bit),
        .ts0_gate  (ts0_gate),
        .fas_frame (fas_frame),
        .evt       (evt)
    );

    crc4mf_align u_align (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .aligned   (aligned),
        .cur_frame (cur_frame),
        .frame_now (frame_now)
    );

    crc4mf_crc_cmp u_crc (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .aligned   (aligned),
        .frame_now (frame_now),
        .smf1_err  (smf1_err),
        .smf2_err  (smf2_err)
    );

    generate
        for (genvar g = 0; g < N_MARKS; g++) begin : g_mark
            assign marks[g] = aligned && (cur_frame == FN_W'(MARK_FRAME[g]));
        end
    endgenerate

    assign fstart   = evt.start;
    assign mf_alarm = !aligned;
    assign f13_mark = marks[0];
    assign f15_mark = marks[1];

endmodule

// File: rtl/crc4mf_checker_sva.sv
module crc4mf_checker_sva
    import crc4mf_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       fas_frame,
    input logic       mf_alarm,
    input logic       smf1_err,
    input logic       smf2_err,
    input logic       f13_mark,
    input logic       f15_mark,
    input logic       fstart,
    input frame_num_t frame_now
);

    p_alarm_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !$rose(mf_alarm));

    p_alarm_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(mf_alarm) |-> $past(fstart && !fas_frame));

    p_err1_window_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(smf1_err) |-> $past(fstart && !mf_alarm && (frame_now == '0)));

    p_err2_window_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(smf2_err) |-> $past(fstart && !mf_alarm && (frame_now == SMF2_FIRST)));

    p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        mf_alarm |-> (!smf1_err && !smf2_err));

    p_marks_aligned_r9: assert property (@(posedge clk) disable iff (rst)
        (f13_mark || f15_mark) |-> !mf_alarm);

    p_mark13_start_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(f13_mark) |-> $past(fstart));

    p_mark15_start_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(f15_mark) |-> $past(fstart));

endmodule

bind crc4_mf_checker crc4mf_checker_sva i_sva (
    .clk       (clk),
    .rst       (rst),
    .fas_frame (fas_frame),
    .mf_alarm  (mf_alarm),
    .smf1_err  (smf1_err),
    .smf2_err  (smf2_err),
    .f13_mark  (f13_mark),
    .f15_mark  (f15_mark),
    .fstart    (fstart),
    .frame_now (frame_now)
);

// File: tb/test_crc4_mf_checker.sv
module test_crc4_mf_checker;

    localparam int FB = 256;
    localparam logic [5:0] ALIGN_BITS = 6'b001011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_bit = 1'b0;
    logic ts0_gate = 1'b0;
    logic fas_frame = 1'b0;
    logic mf_alarm, smf1_err, smf2_err, f13_mark, f15_mark;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    bit       synced, pat_run, v_cur, v_last, cf_cur;
    int       flip_idx;
    logic [3:0] b_acc, tx_crc;
    logic     exp_er1, exp_er2;
    string    tag1, tag2;

    always #10 clk = ~clk;

    crc4_mf_checker i_crc4_mf_checker (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .ts0_gate(ts0_gate),
        .fas_frame(fas_frame), .mf_alarm(mf_alarm), .smf1_err(smf1_err),
        .smf2_err(smf2_err), .f13_mark(f13_mark), .f15_mark(f15_mark)
    );

    function automatic logic [3:0] crc_bit(logic [3:0] c, logic b);
        logic [4:0] t;
        t = {c, 1'b0};
        if (c[3] ^ b) t = t ^ 5'b10011;
        return t[3:0];
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic tick(input logic d, input logic g, input logic f);
        rx_bit    = d;
        ts0_gate  = g;
        fas_frame = f;
        @(negedge clk);
    endtask

    task automatic clear_model();
        synced = 0; pat_run = 0; v_cur = 0; v_last = 0;
        exp_er1 = 0; exp_er2 = 0; tag1 = "R1"; tag2 = "R1";
    endtask

    task automatic check_reset_state();
        chk("R1 alarm", mf_alarm, 1'b1);
        chk("R1 err1", smf1_err, 1'b0);
        chk("R1 err2", smf2_err, 1'b0);
        chk("R1 mark13", f13_mark, 1'b0);
        chk("R1 mark15", f15_mark, 1'b0);
    endtask

    task automatic send_frame(input int fm, input int bad_fm, input bit do_rst);
        bit er_e;
        string atag;
        for (int b = 0; b < FB; b++) begin
            logic d, g, f;
            g = (b < 8);
            f = g && (fm % 2 == 0);
            d = 1'($urandom % 2);
            if (b == 0) begin
                if (fm % 8 == 0) begin
                    if (synced) begin
                        er_e = v_last && cf_cur;
                        if (fm == 0) begin
                            exp_er1 = er_e;
                            tag1 = !v_last ? "R8" : (er_e ? "R6" : "R5");
                        end else begin
                            exp_er2 = er_e;
                            tag2 = !v_last ? "R8" : (er_e ? "R7" : "R5");
                        end
                    end
                    v_last = v_cur;
                    v_cur = synced;
                    cf_cur = 1'($urandom % 2);
                    flip_idx = int'($urandom % 4);
                    tx_crc = b_acc;
                    b_acc = 4'd0;
                end
                if (fm % 2 == 0) begin
                    d = tx_crc[3 - (fm % 8) / 2] ^
                        (cf_cur && (((fm % 8) / 2) == flip_idx));
                end else if (fm <= 11) begin
                    d = ALIGN_BITS[5 - (fm - 1) / 2] ^ (bad_fm == fm);
                    pat_run = ((fm == 1) ? 1'b1 : pat_run) && (bad_fm != fm);
                end else begin
                    d = 1'b1;
                end
            end
            if (!(b == 0 && fm % 8 == 0)) begin
                b_acc = crc_bit(b_acc, (b == 0 && fm % 2 == 0) ? 1'b0 : d);
            end
            rst = do_rst && (b >= FB - 8) && (b < FB - 4);
            tick(d, g, f);
            if (b == 0) begin
                if (fm == MAS_END_B && pat_run) synced = 1;
                atag = (bad_fm >= 0) ? "R4" : ((fm == MAS_END_B) ? "R3" : "R2");
                chk(atag, mf_alarm, !synced);
                chk(synced ? tag1 : "R10", smf1_err, exp_er1);
                chk(synced ? tag2 : "R10", smf2_err, exp_er2);
            end
            if (b == 6) begin
                chk("R9 mark13", f13_mark, synced && fm == 13);
                chk("R9 mark15", f15_mark, synced && fm == 15);
            end
            if (do_rst && b == FB - 5) begin
                clear_model();
                check_reset_state();
            end
        end
        rst = 1'b0;
    endtask

    localparam int MAS_END_B = 11;

    task automatic run_mf(input int first, input int bad_fm, input int rst_fm);
        for (int fm = first; fm < 16; fm++) begin
            send_frame(fm, bad_fm, fm == rst_fm);
        end
    endtask

    initial begin
        void'($urandom(32'd7712));
        clear_model();
        b_acc = 4'd0; tx_crc = 4'd0; cf_cur = 0; flip_idx = 0;
        @(negedge clk);
        repeat (4) tick(1'b0, 1'b0, 1'b0);
        check_reset_state();
        rst = 1'b0;
        repeat (3) tick(1'b0, 1'b0, 1'b0);
        chk("R2 idle alarm", mf_alarm, 1'b1);

        run_mf(5, -1, -1);
        run_mf(0, 7, -1);
        run_mf(0, -1, -1);
        repeat (6) run_mf(0, -1, -1);
        run_mf(0, -1, 3);
        run_mf(0, 9, -1);
        run_mf(0, 1, -1);
        run_mf(0, -1, -1);
        repeat (4) run_mf(0, -1, -1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule